// File: doc/BRIEF.md
# Host-to-PCI Command Translator

This block takes one decoded host-bus request at a time and turns it into zero, one or two PCI transaction descriptors. A request carries a host command code, a length code, eight host byte enables, a 36-bit byte address and a special-cycle type. Each descriptor carries a 4-bit PCI command, a dword-aligned start address, a dword count and four active-low PCI byte enables. A request that maps to no PCI work finishes in its acceptance cycle and never touches the bus request.

When a request does map to PCI work, the block raises `bus_req` and waits for two events. The first is the bus grant (`bus_gnt`, a level). The second is the host commit strobe (`commit`, a one-cycle pulse). They may arrive in either order. Only after both have been seen does the first descriptor appear. `bus_req` drops once the last descriptor has been taken.

Both data interfaces use valid/ready. A transfer happens on a rising edge where valid and ready are both high. `in_ready` is high only while the block is idle, so a new request waits until the previous one is fully drained. While `out_valid` is high and `out_ready` is low, the descriptor on the output holds still.

Top module: `hc_xlate`

## Requirements
- R1: After reset, `in_ready`=1, `out_valid`=0 and `bus_req`=0.
- R2: The following requests complete with no descriptor and with `bus_req` staying low, and `in_ready` stays high:
  - host command 0 (deferred reply);
  - command 8 (branch-trace message);
  - commands 9–15;
  - command 2 (special) with special type 0 (shutdown) or type 2–3;
  - commands 1, 3 and 4 with a length code other than 0;
  - commands 6 and 7 with length code 3;
  - a short access (commands 3, 4, 6, 7 with length code 0) whose eight byte enables are all clear.
- R3: Command 2 with special type 1 (stop-clock acknowledge) gives one descriptor: PCI command 4'b0001 (special cycle), 1 dword, `out_be_n`=4'b0000, address = request address with bits 2:0 cleared.
- R4: Command 1 (interrupt acknowledge) with length code 0 (up to 8 bytes) gives one descriptor: PCI command 4'b0000, 1 dword, `out_be_n`=4'b1110, address bits 2:0 cleared.
- R5: Commands 3 (I/O read) and 4 (I/O write) with length code 0 are split into single-dword cycles with PCI command 4'b0010 and 4'b0011 respectively.
  - The lower half (host byte enables 3:0) goes first and the upper half (7:4) second.
  - A half whose four enables are all clear is skipped.
  - Each cycle's `out_be_n` is the inverse of that half's enables.
  - Its address has bits 2:0 cleared, then bit 2 set to 1 for the upper half.
- R6: Command 5 (read-invalidate), whatever the length code, gives one descriptor: PCI command 4'b1110 (memory read line), 8 dwords, `out_be_n`=0, address bits 4:0 cleared.
- R7: Commands 6 (code read) and 7 (data read) with length code 0 and not all eight enables set follow the split rules of R5, using PCI command 4'b0110 (memory read).
- R8: Commands 6 and 7 with length code 0 and all eight enables set give one descriptor: PCI command 4'b0110, 2 dwords, `out_be_n`=0, address bits 2:0 cleared.
- R9: Commands 6 and 7 with longer length codes give one burst descriptor with `out_be_n`=0:
  - length code 1 (16 bytes): PCI command 4'b0110, 4 dwords, address bits 3:0 cleared;
  - length code 2 (32 bytes): PCI command 4'b1110, 8 dwords, address bits 4:0 cleared.
- R10: For a request that produces descriptors, `bus_req` is high from the cycle after acceptance, and `out_valid` is never raised before both a grant and a commit strobe have been seen for this request.
- R11: While `bus_req` is high, `in_ready` is low. While `out_valid`=1 and `out_ready`=0, the next cycle keeps `out_valid` high with every descriptor field unchanged.
- R12: `bus_req` falls only in the cycle after the last descriptor of a request is accepted, and `in_ready` returns high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block idle, request can be taken |
| in_cmd | input | 4 | Host command code (see R2–R9) |
| in_len | input | 2 | Length code: 0 up to 8 bytes, 1 16 bytes, 2 32 bytes |
| in_be | input | 8 | Host byte enables, active high |
| in_addr | input | 36 | Host byte address |
| in_spc | input | 2 | Special-cycle type: 0 shutdown, 1 stop-clock ack |
| bus_req | output | 1 | PCI bus request |
| bus_gnt | input | 1 | PCI bus grant |
| commit | input | 1 | Host transaction commit pulse |
| out_valid | output | 1 | Descriptor valid |
| out_ready | input | 1 | Descriptor consumer ready |
| out_cmd | output | 4 | PCI command |
| out_addr | output | 36 | Descriptor start address |
| out_dwords | output | 4 | Dword count (1, 2, 4 or 8) |
| out_be_n | output | 4 | PCI byte enables, active low |

## Verification
The cycle-level rules are checked on every clock by assertions:
- output hold under back-pressure;
- `in_ready` low while the bus is requested;
- `bus_req` falling only after an accepted descriptor;
- `out_valid` implying `bus_req`;
- the fixed byte-enable patterns of interrupt-acknowledge and burst descriptors;
- 32-byte alignment of 8-dword bursts.

The translation table itself can only be shown by the bench's scenarios. These cover which command and length combinations yield nothing, the lower-then-upper split order, and skipping an empty half. They also cover exact addresses and dword counts, and waiting for a grant and a commit that arrive in either order.

// File: rtl/hc_xlate_pkg.sv
package hc_xlate_pkg;
  typedef enum logic [3:0] {
    HC_DEFER      = 4'd0,
    HC_IACK       = 4'd1,
    HC_SPECIAL    = 4'd2,
    HC_IO_RD      = 4'd3,
    HC_IO_WR      = 4'd4,
    HC_RD_INVAL   = 4'd5,
    HC_CODE_RD    = 4'd6,
    HC_DATA_RD    = 4'd7,
    HC_BRANCH_MSG = 4'd8
  } hcmd_e;

  localparam logic [3:0] PCI_IACK     = 4'h0;
  localparam logic [3:0] PCI_SPECIAL  = 4'h1;
  localparam logic [3:0] PCI_IO_RD    = 4'h2;
  localparam logic [3:0] PCI_IO_WR    = 4'h3;
  localparam logic [3:0] PCI_MEM_RD   = 4'h6;
  localparam logic [3:0] PCI_MEM_LINE = 4'hE;

  localparam logic [1:0] LEN_SHORT = 2'd0;
  localparam logic [1:0] LEN_16B   = 2'd1;
  localparam logic [1:0] LEN_32B   = 2'd2;

  localparam logic [1:0] SPC_STOPCLK = 2'd1;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SEND} xl_state_e;
endpackage

// File: rtl/hc_xlate_decode.sv
module hc_xlate_decode
  import hc_xlate_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int PBE_W  = 4,
  parameter int DW_W   = 4
) (
  input  logic [3:0]         cmd_i,
  input  logic [1:0]         len_i,
  input  logic [2*PBE_W-1:0] be_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [1:0]         spc_i,
  output logic [1:0]         n_o,
  output logic [3:0]         c0_o,
  output logic [3:0]         c1_o,
  output logic [ADDR_W-1:0]  a0_o,
  output logic [ADDR_W-1:0]  a1_o,
  output logic [DW_W-1:0]    w0_o,
  output logic [PBE_W-1:0]   b0_o,
  output logic [PBE_W-1:0]   b1_o
);
  localparam logic [ADDR_W-1:0] ALIGN8  = ~(ADDR_W'(7));
  localparam logic [ADDR_W-1:0] ALIGN16 = ~(ADDR_W'(15));
  localparam logic [ADDR_W-1:0] ALIGN32 = ~(ADDR_W'(31));
  localparam logic [ADDR_W-1:0] HALF_UP = ADDR_W'(4);
  localparam logic [DW_W-1:0]   DW1 = DW_W'(1);
  localparam logic [DW_W-1:0]   DW2 = DW_W'(2);
  localparam logic [DW_W-1:0]   DW4 = DW_W'(4);
  localparam logic [DW_W-1:0]   DW8 = DW_W'(8);

  logic [PBE_W-1:0]  be_lo, be_hi;
  logic              any_lo, any_hi, all_set, do_split;
  logic [3:0]        split_cmd;
  logic [ADDR_W-1:0] a_lo;

  assign be_lo   = be_i[PBE_W-1:0];
  assign be_hi   = be_i[2*PBE_W-1:PBE_W];
  assign any_lo  = |be_lo;
  assign any_hi  = |be_hi;
  assign all_set = &be_i;
  assign a_lo    = addr_i & ALIGN8;

  always_comb begin
    n_o       = 2'd0;
    c0_o      = PCI_IACK;
    c1_o      = PCI_IACK;
    a0_o      = a_lo;
    a1_o      = a_lo | HALF_UP;
    w0_o      = DW1;
    b0_o      = '0;
    b1_o      = ~be_hi;
    do_split  = 1'b0;
    split_cmd = PCI_MEM_RD;
    case (cmd_i)
      HC_IACK: if (len_i == LEN_SHORT) begin
        n_o  = 2'd1;
        c0_o = PCI_IACK;
        b0_o = {{(PBE_W-1){1'b1}}, 1'b0};
      end
      HC_SPECIAL: if (spc_i == SPC_STOPCLK) begin
        n_o  = 2'd1;
        c0_o = PCI_SPECIAL;
      end
      HC_IO_RD: if (len_i == LEN_SHORT) begin
        do_split  = 1'b1;
        split_cmd = PCI_IO_RD;
      end
      HC_IO_WR: if (len_i == LEN_SHORT) begin
        do_split  = 1'b1;
        split_cmd = PCI_IO_WR;
      end
      HC_RD_INVAL: begin
        n_o  = 2'd1;
        c0_o = PCI_MEM_LINE;
        a0_o = addr_i & ALIGN32;
        w0_o = DW8;
      end
      HC_CODE_RD, HC_DATA_RD: begin
        case (len_i)
          LEN_SHORT: if (all_set) begin
            n_o  = 2'd1;
            c0_o = PCI_MEM_RD;
            w0_o = DW2;
          end else begin
            do_split  = 1'b1;
            split_cmd = PCI_MEM_RD;
          end
          LEN_16B: begin
            n_o  = 2'd1;
            c0_o = PCI_MEM_RD;
            a0_o = addr_i & ALIGN16;
            w0_o = DW4;
          end
          LEN_32B: begin
            n_o  = 2'd1;
            c0_o = PCI_MEM_LINE;
            a0_o = addr_i & ALIGN32;
            w0_o = DW8;
          end
          default: ;
        endcase
      end
      default: ;
    endcase

    if (do_split) begin
      c0_o = split_cmd;
      c1_o = split_cmd;
      if (any_lo) begin
        b0_o = ~be_lo;
        n_o  = any_hi ? 2'd2 : 2'd1;
      end else if (any_hi) begin
        n_o  = 2'd1;
        a0_o = a_lo | HALF_UP;
        b0_o = ~be_hi;
      end
    end
  end
endmodule

// File: rtl/hc_xlate_seq.sv
module hc_xlate_seq
  import hc_xlate_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int PBE_W  = 4,
  parameter int DW_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        n_i,
  input  logic [3:0]        c0_i,
  input  logic [3:0]        c1_i,
  input  logic [ADDR_W-1:0] a0_i,
  input  logic [ADDR_W-1:0] a1_i,
  input  logic [DW_W-1:0]   w0_i,
  input  logic [PBE_W-1:0]  b0_i,
  input  logic [PBE_W-1:0]  b1_i,
  output logic              bus_req,
  input  logic              bus_gnt,
  input  logic              commit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        out_cmd,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DW_W-1:0]   out_dwords,
  output logic [PBE_W-1:0]  out_be_n
);
  localparam logic [DW_W-1:0] DW1 = DW_W'(1);

  xl_state_e         st;
  logic              two, idx, gnt_seen, cmt_seen, accept, go;
  logic [3:0]        r_c0, r_c1;
  logic [ADDR_W-1:0] r_a0, r_a1;
  logic [DW_W-1:0]   r_w0;
  logic [PBE_W-1:0]  r_b0, r_b1;

  assign accept = in_valid && (st == ST_IDLE);
  assign go     = (bus_gnt || gnt_seen) && (commit || cmt_seen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      two      <= 1'b0;
      idx      <= 1'b0;
      gnt_seen <= 1'b0;
      cmt_seen <= 1'b0;
      r_c0     <= '0;
      r_c1     <= '0;
      r_a0     <= '0;
      r_a1     <= '0;
      r_w0     <= '0;
      r_b0     <= '0;
      r_b1     <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept && n_i != 2'd0) begin
          st       <= ST_WAIT;
          two      <= (n_i == 2'd2);
          idx      <= 1'b0;
          gnt_seen <= 1'b0;
          cmt_seen <= commit;
          r_c0     <= c0_i;
          r_c1     <= c1_i;
          r_a0     <= a0_i;
          r_a1     <= a1_i;
          r_w0     <= w0_i;
          r_b0     <= b0_i;
          r_b1     <= b1_i;
        end
        ST_WAIT: begin
          gnt_seen <= gnt_seen | bus_gnt;
          cmt_seen <= cmt_seen | commit;
          if (go) st <= ST_SEND;
        end
        ST_SEND: if (out_ready) begin
          if (idx == two) st <= ST_IDLE;
          else            idx <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign in_ready   = (st == ST_IDLE);
  assign bus_req    = (st != ST_IDLE);
  assign out_valid  = (st == ST_SEND);
  assign out_cmd    = idx ? r_c1 : r_c0;
  assign out_addr   = idx ? r_a1 : r_a0;
  assign out_dwords = idx ? DW1  : r_w0;
  assign out_be_n   = idx ? r_b1 : r_b0;
endmodule

// File: rtl/hc_xlate.sv
module hc_xlate
  import hc_xlate_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int PBE_W  = 4,
  parameter int DW_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_cmd,
  input  logic [1:0]        in_len,
  input  logic [2*PBE_W-1:0] in_be,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_spc,
  output logic              bus_req,
  input  logic              bus_gnt,
  input  logic              commit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        out_cmd,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DW_W-1:0]   out_dwords,
  output logic [PBE_W-1:0]  out_be_n
);
  logic [1:0]        d_n;
  logic [3:0]        d_c0, d_c1;
  logic [ADDR_W-1:0] d_a0, d_a1;
  logic [DW_W-1:0]   d_w0;
  logic [PBE_W-1:0]  d_b0, d_b1;

  hc_xlate_decode #(.ADDR_W(ADDR_W), .PBE_W(PBE_W), .DW_W(DW_W)) u_dec (
    .cmd_i(in_cmd), .len_i(in_len), .be_i(in_be), .addr_i(in_addr), .spc_i(in_spc),
    .n_o(d_n), .c0_o(d_c0), .c1_o(d_c1), .a0_o(d_a0), .a1_o(d_a1),
    .w0_o(d_w0), .b0_o(d_b0), .b1_o(d_b1)
  );

  hc_xlate_seq #(.ADDR_W(ADDR_W), .PBE_W(PBE_W), .DW_W(DW_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .n_i(d_n), .c0_i(d_c0), .c1_i(d_c1), .a0_i(d_a0), .a1_i(d_a1),
    .w0_i(d_w0), .b0_i(d_b0), .b1_i(d_b1),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .commit(commit),
    .out_valid(out_valid), .out_ready(out_ready), .out_cmd(out_cmd),
    .out_addr(out_addr), .out_dwords(out_dwords), .out_be_n(out_be_n)
  );
endmodule

// File: rtl/hc_xlate_chk.sv
module hc_xlate_chk #(
  parameter int ADDR_W = 36,
  parameter int PBE_W  = 4,
  parameter int DW_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              bus_req,
  input logic              out_valid,
  input logic              out_ready,
  input logic [3:0]        out_cmd,
  input logic [ADDR_W-1:0] out_addr,
  input logic [DW_W-1:0]   out_dwords,
  input logic [PBE_W-1:0]  out_be_n
);
  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_cmd) && $stable(out_addr)
                                && $stable(out_dwords) && $stable(out_be_n));

  a_r11_busy_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !in_ready);

  a_r10_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> bus_req);

  a_r12_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $past(out_valid && out_ready) && in_ready);

  a_r4_iack_be: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cmd == 4'h0 |-> out_be_n == 4'b1110 && out_dwords == DW_W'(1));

  a_r9_line_burst: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_dwords == DW_W'(8) |-> out_addr[4:0] == 5'd0 && out_be_n == '0);

  a_r8_burst_all_be: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_dwords != DW_W'(1) |-> out_be_n == '0);
endmodule

bind hc_xlate hc_xlate_chk #(.ADDR_W(ADDR_W), .PBE_W(PBE_W), .DW_W(DW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .bus_req(bus_req),
  .out_valid(out_valid), .out_ready(out_ready), .out_cmd(out_cmd),
  .out_addr(out_addr), .out_dwords(out_dwords), .out_be_n(out_be_n)
);

// File: tb/hc_xlate_tb.sv
module hc_xlate_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_cmd = '0;
  logic [1:0]  in_len = '0;
  logic [7:0]  in_be = '0;
  logic [35:0] in_addr = '0;
  logic [1:0]  in_spc = '0;
  logic        bus_req;
  logic        bus_gnt = 1'b0;
  logic        commit = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  out_cmd;
  logic [35:0] out_addr;
  logic [3:0]  out_dwords;
  logic [3:0]  out_be_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  hc_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cmd(in_cmd), .in_len(in_len), .in_be(in_be), .in_addr(in_addr), .in_spc(in_spc),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .commit(commit),
    .out_valid(out_valid), .out_ready(out_ready), .out_cmd(out_cmd),
    .out_addr(out_addr), .out_dwords(out_dwords), .out_be_n(out_be_n)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [47:0] exp_q[$];
  string       tag_q[$];
  logic        tb_gnt = 1'b0;
  logic        tb_cmt = 1'b0;
  logic        order = 1'b0;
  logic [7:0]  lfsr = 8'hA5;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic expect_d(input string tag, input logic [3:0] c, input logic [35:0] a,
                          input logic [3:0] w, input logic [3:0] b);
    exp_q.push_back({c, a, w, b});
    tag_q.push_back(tag);
  endtask

  // Driver: present one request, then wait for it to drain.
  task automatic send(input string tag, input logic [3:0] c, input logic [1:0] l,
                      input logic [7:0] be, input logic [35:0] a, input logic [1:0] s);
    bit xl;
    xl = (exp_q.size() != 0);
    @(posedge clk); #1;
    in_cmd = c; in_len = l; in_be = be; in_addr = a; in_spc = s; in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    if (xl) begin
      @(negedge clk);
      check(bus_req === 1'b1, {tag, " R10 bus_req after accept"}, 64'(bus_req), 64'd1);
      check(in_ready === 1'b0, {tag, " R11 in_ready low while busy"}, 64'(in_ready), 64'd0);
      while (exp_q.size() != 0 || bus_req) @(negedge clk);
      check(in_ready === 1'b1, {tag, " R12 ready after release"}, 64'(in_ready), 64'd1);
    end else begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        check(bus_req === 1'b0 && out_valid === 1'b0 && in_ready === 1'b1,
              {tag, " R2 no transaction"}, {61'd0, bus_req, out_valid, in_ready}, 64'd1);
      end
    end
  endtask

  // Bus agent: grant and commit in alternating order.
  initial forever begin
    @(negedge clk);
    if (bus_req) begin
      order = ~order;
      if (order) begin
        @(posedge clk); #1 commit = 1'b1; tb_cmt = 1'b1;
        @(posedge clk); #1 commit = 1'b0;
        repeat (2) @(posedge clk);
        #1 bus_gnt = 1'b1; tb_gnt = 1'b1;
      end else begin
        @(posedge clk); #1 bus_gnt = 1'b1; tb_gnt = 1'b1;
        repeat (2) @(posedge clk);
        #1 commit = 1'b1; tb_cmt = 1'b1;
        @(posedge clk); #1 commit = 1'b0;
      end
      do @(negedge clk); while (bus_req);
      @(posedge clk); #1 bus_gnt = 1'b0; tb_gnt = 1'b0; tb_cmt = 1'b0;
    end
  end

  // Consumer back-pressure pattern.
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = lfsr[0] | lfsr[2];
  end

  // Monitor / scoreboard.
  logic        p_stall = 1'b0;
  logic [47:0] p_desc = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_stall)
        check(out_valid === 1'b1 && {out_cmd, out_addr, out_dwords, out_be_n} === p_desc,
              "R11 hold under back-pressure", {15'd0, out_valid, out_cmd, out_addr, out_dwords, out_be_n},
              {16'h0001, p_desc});
      if (out_valid)
        check(tb_gnt && tb_cmt, "R10 valid only after grant and commit",
              {62'd0, tb_gnt, tb_cmt}, 64'd3);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0)
          check(1'b0, "R2 unexpected descriptor", {16'd0, out_cmd, out_addr, out_dwords, out_be_n}, 64'd0);
        else begin
          logic [47:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({out_cmd, out_addr, out_dwords, out_be_n} === e, t,
                {16'd0, out_cmd, out_addr, out_dwords, out_be_n}, {16'd0, e});
        end
      end
      p_stall = out_valid && !out_ready;
      p_desc  = {out_cmd, out_addr, out_dwords, out_be_n};
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'd0, 64'd1);
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(in_ready === 1'b1 && out_valid === 1'b0 && bus_req === 1'b0, "R1 reset state",
          {61'd0, in_ready, out_valid, bus_req}, 64'd4);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1 && out_valid === 1'b0 && bus_req === 1'b0, "R1 after release",
          {61'd0, in_ready, out_valid, bus_req}, 64'd4);

    // R2: requests that yield nothing
    send("R2 deferred reply", 4'd0, 2'd0, 8'hFF, 36'h100, 2'd0);
    send("R2 shutdown", 4'd2, 2'd0, 8'hFF, 36'h100, 2'd0);
    send("R2 branch msg", 4'd8, 2'd0, 8'hFF, 36'h100, 2'd0);
    send("R2 unknown special", 4'd2, 2'd0, 8'hFF, 36'h100, 2'd2);
    send("R2 unknown command", 4'd15, 2'd0, 8'hFF, 36'h100, 2'd0);
    send("R2 io long", 4'd3, 2'd1, 8'h0F, 36'h100, 2'd0);
    send("R2 empty byte enables", 4'd7, 2'd0, 8'h00, 36'h100, 2'd0);
    send("R2 read reserved length", 4'd6, 2'd3, 8'hFF, 36'h100, 2'd0);

    expect_d("R3 stop clock", 4'h1, 36'h0_1234_5678, 4'd1, 4'h0);
    send("R3", 4'd2, 2'd0, 8'h00, 36'h0_1234_567C, 2'd1);

    expect_d("R4 iack", 4'h0, 36'h0, 4'd1, 4'hE);
    send("R4", 4'd1, 2'd0, 8'h0F, 36'h4, 2'd0);

    expect_d("R5 io read lower", 4'h2, 36'hCF8, 4'd1, 4'h3);
    expect_d("R5 io read upper", 4'h2, 36'hCFC, 4'd1, 4'hC);
    send("R5 split", 4'd3, 2'd0, 8'h3C, 36'hCF8, 2'd0);

    expect_d("R5 io write upper only", 4'h3, 36'h84, 4'd1, 4'h0);
    send("R5 upper", 4'd4, 2'd0, 8'hF0, 36'h80, 2'd0);

    expect_d("R5 io write lower only", 4'h3, 36'h80, 4'd1, 4'hE);
    send("R5 lower", 4'd4, 2'd0, 8'h01, 36'h81, 2'd0);

    expect_d("R6 read invalidate", 4'hE, 36'h9_0000_0040, 4'd8, 4'h0);
    send("R6 a", 4'd5, 2'd2, 8'hFF, 36'h9_0000_0044, 2'd0);
    expect_d("R6 read invalidate short", 4'hE, 36'h0, 4'd8, 4'h0);
    send("R6 b", 4'd5, 2'd0, 8'h01, 36'h7, 2'd0);

    expect_d("R7 code read lower", 4'h6, 36'h1000, 4'd1, 4'h1);
    expect_d("R7 code read upper", 4'h6, 36'h1004, 4'd1, 4'h8);
    send("R7", 4'd6, 2'd0, 8'h7E, 36'h1000, 2'd0);

    expect_d("R8 full quadword", 4'h6, 36'h2000, 4'd2, 4'h0);
    send("R8", 4'd7, 2'd0, 8'hFF, 36'h2004, 2'd0);

    expect_d("R9 16 bytes", 4'h6, 36'h3010, 4'd4, 4'h0);
    send("R9 a", 4'd7, 2'd1, 8'hFF, 36'h301C, 2'd0);
    expect_d("R9 32 bytes", 4'hE, 36'hF_FFFF_FFE0, 4'd8, 4'h0);
    send("R9 b", 4'd6, 2'd2, 8'hFF, 36'hF_FFFF_FFFC, 2'd0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R12 all descriptors drained", 64'(exp_q.size()), 64'd0);
    report();
    $finish;
  end
endmodule